// File: doc/BRIEF.md
# Dual Programmable Baud Rate Generator

This block generates two independent oversampling clock enables for a serial port: one for the receiver and one for the transmitter. Both are derived from a single system clock. A host writes one byte to a rate-select register. The low nibble selects the receive rate and the high nibble selects the transmit rate, each from a fixed table of sixteen standard rates. Each channel pulses its enable for one clock cycle at sixteen times the selected baud rate.

The divisor for each rate is the system clock frequency divided by sixteen times the baud rate, rounded to the nearest integer. It is computed at elaboration from the clock parameter. The one fractional rate, 134.5 baud, is computed from twice the baud value, so its divisor is not truncated. A separate reset strobe returns the register to its power-up value, 300 baud on both channels. Changing a channel's rate restarts only that channel's divider.

Top module: `baud_pair_gen`

## Requirements
- R1: After reset `rdData` reads 55h, and both `rxTick` and `txTick` are low while `rst_n` is low.
- R2: A write (`wrEn` high for one cycle) stores `wrData`, and `rdData` returns the last stored byte from the next cycle on.
- R3: Bits 3:0 of the register select the receive rate. Codes 0 to 15 map to 50, 75, 100, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 baud. `rxTick` repeats every round(CLK_HZ / (16 x baud)) cycles.
- R4: Bits 7:4 of the register select the transmit rate from the same table. `txTick` repeats with the matching divisor. Equal nibbles give equal periods.
- R5: Code 3 (134.5 baud) uses the divisor round(2 x CLK_HZ / (16 x 269)), not a divisor based on 134 baud.
- R6: A pulse on `portReset` sets the register to 55h regardless of its previous value, giving 300 baud on both channels.
- R7: When a write or a reset strobe changes a channel's nibble, that channel's counter restarts. The channel's first tick comes divisor-1 cycles after the clock edge that took the write.
- R8: A channel whose nibble does not change keeps its tick phase undisturbed by the write.
- R9: Each tick is high for exactly one cycle whenever the divisor exceeds 1.
- R10: If `portReset` and `wrEn` are high in the same cycle, the reset wins and the register becomes 55h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the rate-select register |
| wrData | input | 8 | Byte written: [3:0] receive code, [7:4] transmit code |
| portReset | input | 1 | Strobe that restores the default code 55h |
| rdData | output | 8 | Current contents of the rate-select register |
| rxTick | output | 1 | One-cycle receive oversampling enable |
| txTick | output | 1 | One-cycle transmit oversampling enable |

## Verification
The assertions take `wrEn` and `portReset` to be clean single-cycle-or-longer levels sampled at the clock edge. They also assume the clock parameter is large enough that every divisor is at least one. The one-cycle pulse check further assumes the divisor exceeds one. The bench drives both strobes only at the falling edge and holds them for whole cycles. It uses a clock parameter whose smallest divisor is five, so every pulse property applies throughout the run.

// File: rtl/baud_pair_pkg.sv
package baud_pair_pkg;

  typedef struct packed {
    logic rxRestart;
    logic txRestart;
  } rate_strobe_t;

  // twice the baud rate, so the 134.5 entry stays exact
  function automatic int unsigned baudTimesTwo(input logic [3:0] sel);
    case (sel)
      4'd0:  return 100;
      4'd1:  return 150;
      4'd2:  return 200;
      4'd3:  return 269;
      4'd4:  return 300;
      4'd5:  return 600;
      4'd6:  return 1200;
      4'd7:  return 2400;
      4'd8:  return 3600;
      4'd9:  return 4000;
      4'd10: return 4800;
      4'd11: return 7200;
      4'd12: return 9600;
      4'd13: return 14400;
      4'd14: return 19200;
      default: return 38400;
    endcase
  endfunction

  // round(clkHz / (16 * baud)) computed as (2*clkHz + 8*b2) / (16*b2)
  function automatic longint unsigned rateDivisor(input longint unsigned clkHz,
                                                  input logic [3:0] sel);
    longint unsigned b2;
    longint unsigned d;
    b2 = 64'(baudTimesTwo(sel));
    d  = (clkHz * 64'd2 + b2 * 64'd8) / (b2 * 64'd16);
    if (d == 64'd0) d = 64'd1;
    return d;
  endfunction

endpackage

// File: rtl/baud_pair_ctrl.sv
module baud_pair_ctrl
  import baud_pair_pkg::*;
#(
  parameter logic [7:0] DEFAULT_CODE = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  input  logic         portReset,
  output logic [7:0]   rateCode,
  output rate_strobe_t strobe
);

  logic [7:0] nextCode;

  always_comb begin
    if (portReset)   nextCode = DEFAULT_CODE;
    else if (wrEn)   nextCode = wrData;
    else             nextCode = rateCode;
    strobe.rxRestart = (nextCode[3:0] != rateCode[3:0]);
    strobe.txRestart = (nextCode[7:4] != rateCode[7:4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rateCode <= DEFAULT_CODE;
    else        rateCode <= nextCode;
  end

  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    portReset |=> (rateCode == DEFAULT_CODE)); // R6
  AST_RESET_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (portReset && wrEn) |=> (rateCode == DEFAULT_CODE)); // R10
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !portReset) |=> (rateCode == $past(wrData))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !portReset) |=> $stable(rateCode)); // R2

endmodule

// File: rtl/baud_pair_chan.sv
module baud_pair_chan
  import baud_pair_pkg::*;
#(
  parameter int unsigned CLK_HZ = 24_000_000,
  parameter int unsigned CNT_W  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic [CNT_W-1:0] divSel;
  logic [CNT_W-1:0] cnt;

  always_comb divSel = CNT_W'(rateDivisor(64'(CLK_HZ), sel));

  assign tick = (cnt == divSel - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < divSel); // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divSel > 1) |=> (!tick || divSel == 1)); // R9

endmodule

// File: rtl/baud_pair_dp.sv
module baud_pair_dp
  import baud_pair_pkg::*;
#(
  parameter int unsigned CLK_HZ = 24_000_000,
  parameter int unsigned CNT_W  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   rateCode,
  input  rate_strobe_t strobe,
  output logic [1:0]   ticks
);

  logic [1:0] restarts;
  assign restarts = {strobe.txRestart, strobe.rxRestart};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    baud_pair_chan #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (rateCode[4*ch +: 4]),
      .restart(restarts[ch]),
      .tick   (ticks[ch])
    );
  end

  AST_STILL_WHEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!restarts[1] && $past(ticks[1]) && $past(rst_n)) |-> !ticks[1] || $stable(ticks[1]) == 1'b0); // R8

endmodule

// File: rtl/baud_pair_gen.sv
module baud_pair_gen
  import baud_pair_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 24_000_000,
  parameter logic [7:0]  DEFAULT_CODE = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       portReset,
  output logic [7:0] rdData,
  output logic       rxTick,
  output logic       txTick
);

  localparam int unsigned MAX_DIV = CLK_HZ / 800 + 2;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV) + 1;

  rate_strobe_t strobe;
  logic [7:0]   rateCode;
  logic [1:0]   ticks;

  baud_pair_ctrl #(.DEFAULT_CODE(DEFAULT_CODE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .portReset(portReset),
    .rateCode (rateCode),
    .strobe   (strobe)
  );

  baud_pair_dp #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rateCode(rateCode),
    .strobe  (strobe),
    .ticks   (ticks)
  );

  assign rdData = rateCode;
  assign rxTick = ticks[0];
  assign txTick = ticks[1];

endmodule

// File: tb/baud_pair_gen_tb.sv
module baud_pair_gen_tb;

  localparam int unsigned CLK_HZ = 1_536_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic portReset = 1'b0;
  logic [7:0] rdData;
  logic rxTick, txTick;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_pair_gen #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .portReset(portReset), .rdData(rdData), .rxTick(rxTick), .txTick(txTick)
  );

  function automatic int expDiv(input logic [3:0] c);
    real baud;
    case (c)
      4'd0: baud = 50.0;    4'd1: baud = 75.0;    4'd2: baud = 100.0;
      4'd3: baud = 134.5;   4'd4: baud = 150.0;   4'd5: baud = 300.0;
      4'd6: baud = 600.0;   4'd7: baud = 1200.0;  4'd8: baud = 1800.0;
      4'd9: baud = 2000.0;  4'd10: baud = 2400.0; 4'd11: baud = 3600.0;
      4'd12: baud = 4800.0; 4'd13: baud = 7200.0; 4'd14: baud = 9600.0;
      default: baud = 19200.0;
    endcase
    return $rtoi(real'(CLK_HZ) / (16.0 * baud) + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v, input logic rstAlso, output int w);
    @(negedge clk);
    wrEn = 1'b1; wrData = v; portReset = rstAlso;
    @(negedge clk);
    wrEn = 1'b0; portReset = 1'b0;
    w = cyc;
  endtask

  task automatic pulseReset(output int w);
    @(negedge clk);
    portReset = 1'b1;
    @(negedge clk);
    portReset = 1'b0;
    w = cyc;
  endtask

  task automatic waitTick(input bit useTx, input bit skip, output int at);
    if (skip) @(negedge clk);
    while (!(useTx ? txTick : rxTick)) @(negedge clk);
    at = cyc;
  endtask

  task automatic measure(input int w, input logic [7:0] oldC, input logic [7:0] newC,
                         input string tag);
    int a0, a1, b0, b1;
    fork
      begin waitTick(1'b0, 1'b0, a0); waitTick(1'b0, 1'b1, a1); end
      begin waitTick(1'b1, 1'b0, b0); waitTick(1'b1, 1'b1, b1); end
    join
    check({"R3 rx period ", tag}, a1 - a0, expDiv(newC[3:0]));
    check({"R4 tx period ", tag}, b1 - b0, expDiv(newC[7:4]));
    if (newC[3:0] != oldC[3:0])
      check({"R7 rx restart ", tag}, a0, w + expDiv(newC[3:0]) - 1);
    if (newC[7:4] != oldC[7:4])
      check({"R7 tx restart ", tag}, b0, w + expDiv(newC[7:4]) - 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int w, t0, t1;
    logic [7:0] cur, nxt;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    check("R1 rx low in reset", int'(rxTick), 0);
    check("R1 tx low in reset", int'(txTick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 default code", int'(rdData), 8'h55);
    cur = 8'h55;

    // R5: fractional rate on both channels
    writeReg(8'h33, 1'b0, w);
    check("R2 readback 33h", int'(rdData), 8'h33);
    check("R5 divisor", expDiv(4'd3), 714);
    measure(w, cur, 8'h33, "134.5");
    cur = 8'h33;

    // R8: change only the rx nibble, tx phase must continue
    writeReg(8'h99, 1'b0, w);
    cur = 8'h99;
    waitTick(1'b1, 1'b0, t0);
    writeReg(8'h9A, 1'b0, w);
    waitTick(1'b1, 1'b0, t1);
    check("R8 tx phase kept", t1 - t0, expDiv(4'd9));
    cur = 8'h9A;

    // R6: reset strobe restores default
    writeReg(8'hFF, 1'b0, w);
    cur = 8'hFF;
    pulseReset(w);
    check("R6 code after strobe", int'(rdData), 8'h55);
    measure(w, cur, 8'h55, "default");
    cur = 8'h55;

    // R10: reset wins over a simultaneous write
    writeReg(8'h00, 1'b1, w);
    check("R10 reset priority", int'(rdData), 8'h55);

    // R9: single-cycle pulses
    waitTick(1'b0, 1'b1, t0);
    @(negedge clk);
    check("R9 rx one cycle", int'(rxTick), 0);

    // random codes, fast to moderate rates
    for (int i = 0; i < 10; i++) begin
      nxt = 8'($urandom);
      nxt[3:0] = 4'(5 + ($urandom % 11));
      nxt[7:4] = 4'(5 + ($urandom % 11));
      writeReg(nxt, 1'b0, w);
      check("R2 readback random", int'(rdData), int'(nxt));
      measure(w, cur, nxt, "random");
      cur = nxt;
    end

    // slowest rate once, equal nibbles
    writeReg(8'h00, 1'b0, w);
    measure(w, cur, 8'h00, "50 baud");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule